// File: doc/BRIEF.md
# Program ROM Window Mapper

This block sits between a CPU and its program ROM. It translates CPU addresses in the range 0x6000 to 0xFFFF into a flat ROM address. It also raises a valid flag whenever the address falls inside a window that the current layout maps. Four 8-bit bank registers hold inner bank numbers. Four 8-bit control registers choose the window layout and supply a 2-bit outer block number, which selects one 512 KB region of the ROM.

The CPU loads these registers through a write port made of a strobe, a 16-bit address and a data byte. Each register takes its new value on the clock edge that samples the strobe. The translation path is purely combinational from the register contents and the CPU address. The ROM itself and the read-data multiplexing lie outside this block.

The layout is chosen by the low two bits of control register 0:

- **Two 16 KB windows.** Used when the field is 1.
- **Four 8 KB windows.** Used when the field is 0 or 3, or when it is 2 with control 0 bit 2 set.
- **8 KB windows with a fixed top.** Used when the field is 2 and bit 2 is clear. The window at 0xE000 is held to the highest inner bank, and an extra window at 0x6000 can be switched on.

Top module: `prgmap_top`

## Requirements
- R1: After reset, every bank and control register holds 0xFF. The layout is therefore four 8 KB windows with outer block 3, and CPU address 0x8000 maps to ROM address 0x1FE000.
- R2: A write lands in bank register N (N = wr_addr[1:0]) when wr_addr[15:12] is 0x8 and wr_addr[2] is 0; address bits 11:3 are ignored. A write with wr_addr[15:12] = 0x8 and wr_addr[2] = 1 changes no register.
- R3: A write with wr_addr[15:12] = 0xD lands in control register wr_addr[1:0], whatever bits 11:2 hold.
- R4: When control 0 bits 1:0 = 1, the block uses two 16 KB windows. Addresses 0x8000–0xBFFF map to bank = {ctl3[2:1], bank0[4:0]}, and addresses 0xC000–0xFFFF map to bank = {ctl3[2:1], bank2[4:0]}. The ROM address is {bank, cpu_addr[13:0]}.
- R5: When control 0 bits 1:0 = 0 or 3, or = 2 with ctl0[2] = 1, the block uses four 8 KB windows. Window k (k = cpu_addr[14:13]) maps to {ctl3[2:1], bank_k[5:0], cpu_addr[12:0]}.
- R6: When control 0 bits 1:0 = 2 and ctl0[2] = 0, windows 0–2 behave as in R5, and the window at 0xE000 maps to inner bank 0x3F under the same outer block.
- R7: In the R6 layout with ctl0[7] = 1, the range 0x6000–0x7FFF maps to {ctl3[2:1], bank3[5:0], cpu_addr[12:0]} with valid high.
- R8: rom_valid is low for cpu_addr below 0x6000. It is also low for 0x6000–0x7FFF unless the R7 condition holds. It is high for every address from 0x8000 upward.
- R9: A register write changes rom_addr only from the cycle after the strobe. In the strobe cycle itself, the mapping still reflects the old register value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| cpu_addr | input | 16 | CPU address to translate |
| rom_addr | output | 21 | Translated ROM byte address |
| rom_valid | output | 1 | High when cpu_addr lies in a mapped window |

## Verification
Register loading and address translation can happen in the same cycle. This occurs when the CPU rewrites a bank register while the translation input already points into the window that register feeds. The bench provokes this case by holding cpu_addr on that window while it drives the strobe. It then compares rom_addr twice. In the strobe cycle the value must still show the old bank, and one cycle later it must show the new bank.

// File: rtl/prgmap_pkg.sv
package prgmap_pkg;
  localparam int REG_W     = 8;
  localparam int OUTER_W   = 2;
  localparam int INNER8_W  = 6;
  localparam int INNER16_W = 5;
  localparam int OFF8_W    = 13;
  localparam int OFF16_W   = 14;
  localparam int ROM_AW    = OUTER_W + INNER8_W + OFF8_W;

  typedef enum logic [1:0] {
    LAYOUT_QUAD8  = 2'd0,
    LAYOUT_DUAL16 = 2'd1,
    LAYOUT_FIXTOP = 2'd2
  } layout_e;

  function automatic logic [OUTER_W+INNER16_W-1:0] page16(
      input logic [REG_W-1:0] r, input logic [OUTER_W-1:0] o);
    return {o, r[INNER16_W-1:0]};
  endfunction

  function automatic logic [OUTER_W+INNER8_W-1:0] page8(
      input logic [REG_W-1:0] r, input logic [OUTER_W-1:0] o);
    return {o, r[INNER8_W-1:0]};
  endfunction
endpackage

// File: rtl/prgmap_regfile.sv
module prgmap_regfile #(
  parameter int N = 4,
  parameter int W = 8,
  localparam int IW = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [IW-1:0]       idx,
  input  logic [W-1:0]        din,
  output logic [N-1:0][W-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         q[i] <= '1;
      else if (we && idx == IW'(i))       q[i] <= din;
    end
  end

  p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> q[$past(idx)] == $past(din));
  p_reset_ones_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> q == '1);
endmodule

// File: rtl/prgmap_layout.sv
module prgmap_layout
  import prgmap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] ctl0,
  output layout_e          layout,
  output logic             xwin_en
);
  always_comb begin
    unique case (ctl0[1:0])
      2'd1:    layout = LAYOUT_DUAL16;
      2'd2:    layout = ctl0[2] ? LAYOUT_QUAD8 : LAYOUT_FIXTOP;
      default: layout = LAYOUT_QUAD8;
    endcase
    xwin_en = (layout == LAYOUT_FIXTOP) && ctl0[7];
  end

  p_xwin_only_fixtop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xwin_en |-> ctl0[1:0] == 2'd2 && !ctl0[2]);
endmodule

// File: rtl/prgmap_xlate.sv
module prgmap_xlate
  import prgmap_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  layout_e                layout,
  input  logic                   xwin_en,
  input  logic [3:0][REG_W-1:0]  bank_q,
  input  logic [OUTER_W-1:0]     outer,
  input  logic [15:0]            cpu_addr,
  output logic [ROM_AW-1:0]      rom_addr,
  output logic                   rom_valid
);
  logic [2:0] region;
  logic [1:0] slot;
  logic [REG_W-1:0] sel16;
  logic [OUTER_W+INNER8_W-1:0] pg8;

  always_comb begin
    region    = cpu_addr[15:13];
    slot      = cpu_addr[14:13];
    sel16     = cpu_addr[14] ? bank_q[2] : bank_q[0];
    pg8       = page8(bank_q[slot], outer);
    rom_addr  = '0;
    rom_valid = 1'b0;
    if (cpu_addr[15]) begin
      rom_valid = 1'b1;
      unique case (layout)
        LAYOUT_DUAL16: rom_addr = {page16(sel16, outer), cpu_addr[OFF16_W-1:0]};
        LAYOUT_FIXTOP: rom_addr = (slot == 2'd3)
                                  ? {outer, {INNER8_W{1'b1}}, cpu_addr[OFF8_W-1:0]}
                                  : {pg8, cpu_addr[OFF8_W-1:0]};
        default:       rom_addr = {pg8, cpu_addr[OFF8_W-1:0]};
      endcase
    end else if (region == 3'd3 && xwin_en) begin
      rom_valid = 1'b1;
      rom_addr  = {page8(bank_q[3], outer), cpu_addr[OFF8_W-1:0]};
    end
  end

  p_low_invalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[15:13] < 3'd3 |-> !rom_valid);
  p_xwin_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:13] == 3'd3 && !xwin_en) |-> !rom_valid);
  p_fixed_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (layout == LAYOUT_FIXTOP && cpu_addr[15:13] == 3'd7) |-> rom_addr[18:13] == 6'h3F);
  p_offset16_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (layout == LAYOUT_DUAL16 && cpu_addr[15]) |-> rom_valid && rom_addr[13:0] == cpu_addr[13:0]);
endmodule

// File: rtl/prgmap_top.sv
module prgmap_top
  import prgmap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [15:0]       wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [15:0]       cpu_addr,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_valid
);
  localparam int NBANK = 4;
  localparam int NCTL  = 4;

  logic bank_we, ctl_we;
  logic [NBANK-1:0][REG_W-1:0] bank_q;
  logic [NCTL-1:0][REG_W-1:0]  ctl_q;
  layout_e layout;
  logic xwin_en;

  assign bank_we = wr_en && wr_addr[15:12] == 4'h8 && !wr_addr[2];
  assign ctl_we  = wr_en && wr_addr[15:12] == 4'hD;

  prgmap_regfile #(.N(NBANK), .W(REG_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(bank_we), .idx(wr_addr[1:0]),
    .din(wr_data), .q(bank_q));

  prgmap_regfile #(.N(NCTL), .W(REG_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .we(ctl_we), .idx(wr_addr[1:0]),
    .din(wr_data), .q(ctl_q));

  prgmap_layout u_layout (
    .clk(clk), .rst_n(rst_n), .ctl0(ctl_q[0]), .layout(layout), .xwin_en(xwin_en));

  prgmap_xlate u_xlate (
    .clk(clk), .rst_n(rst_n), .layout(layout), .xwin_en(xwin_en),
    .bank_q(bank_q), .outer(ctl_q[3][2:1]), .cpu_addr(cpu_addr),
    .rom_addr(rom_addr), .rom_valid(rom_valid));

  p_alias_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[15:12] == 4'h8 && wr_addr[2]) |=> $stable(bank_q));
  p_ctl_land_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[15:12] == 4'hD) |=> ctl_q[$past(wr_addr[1:0])] == $past(wr_data));
endmodule

// File: tb/sim_prgmap_top.sv
`timescale 1ns/1ps
module sim_prgmap_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] cpu_addr = '0;
  logic [20:0] rom_addr;
  logic rom_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [7:0] bk [4];
  logic [7:0] ct [4];

  always #2.5 clk = ~clk;

  prgmap_top u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cpu_addr(cpu_addr), .rom_addr(rom_addr), .rom_valid(rom_valid));

  function automatic logic [21:0] model(input logic [15:0] a);
    int mode, outer, page, inner, r;
    bit fix;
    mode  = int'(ct[0] & 8'h03);
    outer = int'(ct[3] >> 1) & 3;
    fix   = (mode == 2) && !ct[0][2];
    if (a < 16'h6000) return '0;
    if (a < 16'h8000) begin
      if (fix && ct[0][7])
        return {1'b1, 21'(outer * 524288 + (int'(bk[3]) % 64) * 8192 + int'(a) % 8192)};
      return '0;
    end
    if (mode == 1) begin
      r = (a >= 16'hC000) ? int'(bk[2]) : int'(bk[0]);
      return {1'b1, 21'(outer * 524288 + (r % 32) * 16384 + int'(a) % 16384)};
    end
    page  = (int'(a) - 32768) / 8192;
    inner = (fix && page == 3) ? 63 : int'(bk[page]) % 64;
    return {1'b1, 21'(outer * 524288 + inner * 8192 + int'(a) % 8192)};
  endfunction

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if ((a & 16'hF007) <= 16'h8003 && (a & 16'hF007) >= 16'h8000) bk[a[1:0]] = d;
    if (a[15:12] == 4'hD) ct[a[1:0]] = d;
  endtask

  task automatic chk(input logic [15:0] a, input string req);
    logic [21:0] e;
    cpu_addr = a;
    #1;
    e = model(a);
    n_chk++;
    if (rom_valid !== e[21] || (e[21] && rom_addr !== e[20:0])) begin
      n_bad++;
      $display("FAIL %s addr=%h got valid=%b rom=%h exp valid=%b rom=%h",
               req, a, rom_valid, rom_addr, e[21], e[20:0]);
    end
  endtask

  task automatic t_reset;
    chk(16'h8000, "R1");
    n_chk++;
    if (rom_addr !== 21'h1FE000) begin
      n_bad++; $display("FAIL R1 got %h exp %h", rom_addr, 21'h1FE000);
    end
    chk(16'hE123, "R1");
    chk(16'h6000, "R8");
  endtask

  task automatic t_decode;
    wr(16'hD000, 8'h00);
    wr(16'hD003, 8'h02);
    wr(16'h8FF1, 8'h15);
    chk(16'hA010, "R2");
    wr(16'h8005, 8'h22);
    chk(16'hA010, "R2");
    wr(16'h8002, 8'h3C);
    chk(16'hC777, "R2");
    wr(16'hDAB3, 8'h04);
    chk(16'hC777, "R3");
  endtask

  task automatic t_quad8;
    wr(16'h8000, 8'hC1); wr(16'h8003, 8'h7E);
    wr(16'hD000, 8'h03);
    for (int i = 0; i < 4; i++) chk(16'h8000 + 16'(i) * 16'h2000 + 16'h0ABC, "R5");
    wr(16'hD000, 8'h06);
    chk(16'hE001, "R5");
    chk(16'h7000, "R8");
  endtask

  task automatic t_dual16;
    wr(16'hD000, 8'h01); wr(16'hD003, 8'h06);
    wr(16'h8000, 8'hEA); wr(16'h8002, 8'h1F);
    chk(16'h8000, "R4"); chk(16'hBFFF, "R4");
    chk(16'hC000, "R4"); chk(16'hFFFF, "R4");
    chk(16'h6800, "R8");
  endtask

  task automatic t_fixtop;
    wr(16'hD000, 8'h02); wr(16'hD003, 8'h00);
    wr(16'h8003, 8'h05);
    chk(16'hE000, "R6"); chk(16'hFFFF, "R6"); chk(16'hA123, "R6");
    chk(16'h6000, "R8");
    wr(16'hD000, 8'h82);
    chk(16'h6000, "R7"); chk(16'h7FFF, "R7");
    chk(16'h5FFF, "R8"); chk(16'h0000, "R8");
    wr(16'hD003, 8'h04);
    chk(16'hE456, "R6"); chk(16'h6456, "R7");
  endtask

  task automatic t_same_cycle;
    logic [21:0] old_e;
    wr(16'hD000, 8'h00);
    wr(16'h8001, 8'h11);
    @(negedge clk);
    cpu_addr = 16'hA200;
    #0.5;
    old_e = model(16'hA200);
    wr_en = 1'b1; wr_addr = 16'h8001; wr_data = 8'h2A;
    #0.5;
    n_chk++;
    if (rom_addr !== old_e[20:0]) begin
      n_bad++; $display("FAIL R9 strobe cycle got %h exp %h", rom_addr, old_e[20:0]);
    end
    @(negedge clk);
    wr_en = 1'b0;
    bk[1] = 8'h2A;
    chk(16'hA200, "R9");
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired got hang exp completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4; i++) begin bk[i] = 8'hFF; ct[i] = 8'hFF; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_quad8();
    t_dual16();
    t_fixtop();
    t_same_cycle();
    finish_run();
  end
endmodule